// File: doc/BRIEF.md
# Width-Reconfigurable Lane Multiplier

This block multiplies unsigned operands packed in pairs inside a single 32-bit input word. A two-bit width code picks the lane size. In 4-bit mode the word carries four operand pairs and the block returns four 8-bit products. In 8-bit mode it carries two pairs and returns two 16-bit products. In 16-bit mode it carries one pair and returns one 32-bit product. Inside each pair, the upper half of the field is the first operand and the lower half is the second.

The arithmetic is a single bank of sixteen 4x4 array multipliers. Groups of four nibble products are combined into four 8x8 products, and those are combined into one 16x16 product. Each mode uses as much of this tree as it needs.

The input word, the mode and two stage enables are registered on every clock. One enable puts a register after the nibble products, and the other puts a register after the byte products. When an enable is low, or the current mode does not reach that level of the tree, the stage is bypassed combinationally. A valid flag travels with the data and lines up with the result. The configuration inputs must be held steady while any accepted word is still in flight.

Top module: `lane_mul32`

## Requirements
- R1: While reset is asserted, and after it is released until a word is accepted, `out_vld` is 0 and `out_prod` is 0.
- R2: With width code 00, output byte i (bits 8i+7..8i) equals input bits 8i+7..8i+4 times input bits 8i+3..8i, for i = 0..3.
- R3: With width code 01, `out_prod[15:0]` equals `in_word[15:8]` times `in_word[7:0]`, and `out_prod[31:16]` equals `in_word[31:24]` times `in_word[23:16]`.
- R4: With width code 11, `out_prod` equals `in_word[31:16]` times `in_word[15:0]`.
- R5: In 4-bit mode the result appears right after the capturing clock edge (latency 1), whatever the two stage enables are.
- R6: In 8-bit mode the latency is 1 plus `pipe8_en`. `pipe16_en` has no effect on it.
- R7: In 16-bit mode the latency is 1 plus `pipe8_en` plus `pipe16_en`.
- R8: Words may be presented on consecutive cycles. Every accepted word yields exactly one valid result, in order.
- R9: `out_vld` is high only in the cycle that is exactly one latency after a cycle in which `in_vld` was high.
- R10: Width code 10 behaves exactly like code 11 (16-bit mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | Packed operand pairs |
| width_sel | input | 2 | Lane width: 00 = 4-bit, 01 = 8-bit, 1x = 16-bit |
| pipe8_en | input | 1 | Enables the register after the nibble products |
| pipe16_en | input | 1 | Enables the register after the byte products |
| out_vld | output | 1 | Result valid |
| out_prod | output | 32 | Packed products |

## Verification
A word is driven before clock edge E. Its result is due just after edge E+L-1. L is 1 in 4-bit mode, 1 + `pipe8_en` in 8-bit mode, and 1 + `pipe8_en` + `pipe16_en` in 16-bit mode.

The bench drives and samples on falling edges. It keeps a short ring of what it drove and, on each falling edge, compares the outputs with the entry driven exactly L cycles earlier, including the cycles where nothing valid was sent. After each burst it leaves idle cycles so the pipeline drains before the configuration changes.

Every combination of width code and enables is swept. The sweep also applies all nibble pairs in 4-bit mode and all byte pairs in 8-bit mode.

// File: rtl/lane_mul32.sv
module lane_mul32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [31:0] in_word,
  input  logic [1:0]  width_sel,
  input  logic        pipe8_en,
  input  logic        pipe16_en,
  output logic        out_vld,
  output logic [31:0] out_prod
);
  localparam int NIB   = 4;
  localparam int BYTE  = 2 * NIB;
  localparam int HALF  = 2 * BYTE;
  localparam int WORD  = 2 * HALF;
  localparam int UNITS = 4;

  function automatic logic [BYTE-1:0] mul4(input logic [NIB-1:0] a, input logic [NIB-1:0] b);
    logic [BYTE-1:0] acc;
    acc = '0;
    for (int i = 0; i < NIB; i++)
      if (b[i]) acc = acc + ({{NIB{1'b0}}, a} << i);
    return acc;
  endfunction

  logic [WORD-1:0] w_q;
  logic [1:0]      sel_q;
  logic            p8_q, p16_q, v_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w_q <= '0; sel_q <= '0; p8_q <= 1'b0; p16_q <= 1'b0; v_q <= 1'b0;
    end else begin
      w_q <= in_word; sel_q <= width_sel; p8_q <= pipe8_en; p16_q <= pipe16_en; v_q <= in_vld;
    end

  wire is16 = sel_q[1];
  wire is4  = (sel_q == 2'b00);
  wire use1 = p8_q & ~is4;
  wire use2 = p16_q & is16;

  logic [UNITS-1:0][BYTE-1:0] opx, opy;
  always_comb begin
    opx = '0;
    opy = '0;
    if (is16) begin
      opx[0] = w_q[23:16]; opy[0] = w_q[7:0];
      opx[1] = w_q[31:24]; opy[1] = w_q[7:0];
      opx[2] = w_q[23:16]; opy[2] = w_q[15:8];
      opx[3] = w_q[31:24]; opy[3] = w_q[15:8];
    end else if (!is4) begin
      opx[0] = w_q[15:8];  opy[0] = w_q[7:0];
      opx[3] = w_q[31:24]; opy[3] = w_q[23:16];
    end else begin
      for (int k = 0; k < UNITS; k++) begin
        opx[k] = {{NIB{1'b0}}, w_q[BYTE*k+NIB +: NIB]};
        opy[k] = {{NIB{1'b0}}, w_q[BYTE*k +: NIB]};
      end
    end
  end

  logic [UNITS-1:0][3:0][BYTE-1:0] pp_c, pp_r, pp_s;
  logic [UNITS-1:0][HALF-1:0]      m8_c, m8_r, m8_s;
  logic                            v1_r, v2_r, v_s1;

  for (genvar k = 0; k < UNITS; k++) begin : g_unit
    for (genvar j = 0; j < 4; j++) begin : g_nib
      assign pp_c[k][j] = mul4(j[0] ? opx[k][BYTE-1:NIB] : opx[k][NIB-1:0],
                               j[1] ? opy[k][BYTE-1:NIB] : opy[k][NIB-1:0]);
    end
    assign m8_c[k] = (HALF'(pp_s[k][3]) << BYTE)
                   + ((HALF'(pp_s[k][1]) + HALF'(pp_s[k][2])) << NIB)
                   + HALF'(pp_s[k][0]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pp_r <= '0; m8_r <= '0; v1_r <= 1'b0; v2_r <= 1'b0;
    end else begin
      pp_r <= pp_c; v1_r <= v_q;
      m8_r <= m8_c; v2_r <= v_s1;
    end

  assign pp_s = use1 ? pp_r : pp_c;
  assign v_s1 = use1 ? v1_r : v_q;
  assign m8_s = use2 ? m8_r : m8_c;
  assign out_vld = use2 ? v2_r : v_s1;

  wire [WORD-1:0] m16 = (WORD'(m8_s[3]) << HALF)
                      + ((WORD'(m8_s[1]) + WORD'(m8_s[2])) << BYTE)
                      + WORD'(m8_s[0]);

  always_comb
    if (is16)     out_prod = m16;
    else if (!is4) out_prod = {m8_s[3], m8_s[0]};
    else          out_prod = {m8_s[3][BYTE-1:0], m8_s[2][BYTE-1:0], m8_s[1][BYTE-1:0], m8_s[0][BYTE-1:0]};

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  p_lat_w4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && width_sel == 2'b00) |=> out_vld);

  p_lat_w8_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && sel_q == 2'b01 && p8_q && $past(sel_q) == 2'b01 && $past(p8_q)
     && $past(in_vld, 2)) |-> out_vld);

  p_lat_w16_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && sel_q[1] && p8_q && p16_q && $past(sel_q[1]) && $past(p8_q) && $past(p16_q)
     && $past(sel_q[1], 2) && $past(p8_q, 2) && $past(p16_q, 2) && $past(in_vld, 3)) |-> out_vld);

  p_val_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_vld) |-> ($past(in_vld) || $past(in_vld, 2) || $past(in_vld, 3)));

  p_w4_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && out_vld && sel_q == 2'b00) |->
      out_prod[7:0] == ({4'b0, $past(in_word[7:4])} * {4'b0, $past(in_word[3:0])}));
endmodule

// File: tb/lane_mul32_tb_top.sv
module lane_mul32_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [31:0] in_word = '0;
  logic [1:0]  width_sel = '0;
  logic        pipe8_en = 1'b0;
  logic        pipe16_en = 1'b0;
  logic        out_vld;
  logic [31:0] out_prod;

  int n_chk = 0;
  int n_bad = 0;

  lane_mul32 dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
    .width_sel(width_sel), .pipe8_en(pipe8_en), .pipe16_en(pipe16_en),
    .out_vld(out_vld), .out_prod(out_prod)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] ref_prod(input logic [1:0] s, input logic [31:0] w);
    logic [31:0] r;
    r = '0;
    if (s[1]) r = {16'b0, w[31:16]} * {16'b0, w[15:0]};
    else if (s == 2'b01) begin
      r[15:0]  = {8'b0, w[15:8]} * {8'b0, w[7:0]};
      r[31:16] = {8'b0, w[31:24]} * {8'b0, w[23:16]};
    end else
      for (int i = 0; i < 4; i++)
        r[8*i +: 8] = {4'b0, w[8*i+4 +: 4]} * {4'b0, w[8*i +: 4]};
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_cfg(input logic [1:0] s, input logic p8, input logic p16,
                         input int n, input int pat);
    logic [31:0] hw [8];
    logic        hv [8];
    int lat, sent, got;
    string lt, vt;
    lat = (s == 2'b00) ? 1 : (s == 2'b01) ? 1 + int'(p8) : 1 + int'(p8) + int'(p16);
    lt  = (s == 2'b00) ? "R5" : (s == 2'b01) ? "R6" : "R7";
    vt  = (s == 2'b00) ? "R2" : (s == 2'b01) ? "R3" : (s == 2'b10) ? "R10" : "R4";
    for (int i = 0; i < 8; i++) begin hv[i] = 1'b0; hw[i] = '0; end
    sent = 0; got = 0;
    width_sel = s; pipe8_en = p8; pipe16_en = p16;
    for (int t = 0; t < n + 4; t++) begin
      @(negedge clk);
      if (t >= lat && hv[(t - lat) % 8]) begin
        got += int'(out_vld);
        check(lt, {31'b0, out_vld}, 32'd1);
        if (out_vld) check(vt, out_prod, ref_prod(s, hw[(t - lat) % 8]));
      end else
        check("R9", {31'b0, out_vld}, 32'd0);
      if (t < n) begin
        if (pat == 0) begin
          in_vld  = (t % 5 != 2);
          in_word = (t == 0) ? 32'hFFFF_FFFF : (t * 32'h9E37_79B1) ^ (t << 7);
        end else begin
          in_vld  = 1'b1;
          in_word = {t[15:0], t[15:0]};
        end
      end else
        in_vld = 1'b0;
      hv[t % 8] = in_vld;
      hw[t % 8] = in_word;
      sent += int'(in_vld);
    end
    check("R8", got, sent);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {31'b0, out_vld}, 32'd0);
    check("R1", out_prod, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {31'b0, out_vld}, 32'd0);
    check("R1", out_prod, 32'd0);
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++)
        run_cfg(s[1:0], c[0], c[1], 200, 0);
    run_cfg(2'b00, 1'b1, 1'b1, 256, 1);
    run_cfg(2'b01, 1'b1, 1'b0, 65536, 1);
    run_cfg(2'b11, 1'b1, 1'b1, 300, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule